// File: doc/BRIEF.md
# Frame Timestamp Trailer Appender

This block sits in an image capture path between a camera-side byte stream and the byte stream that feeds a DMA engine. Every pixel byte passes through untouched and in order. Once the last byte of a frame has gone out, the block adds a fixed 32-byte trailer. The trailer records when the frame started and which frame it was. Capture is triggered by the rising edge of a frame-valid strobe. At that edge the block latches four values: the whole-seconds time from an external time source, the number of clock ticks since the last second boundary, the length in ticks of the previous full second, and a running frame number.

The latched values have to survive the whole frame, because the trailer goes out only after the final pixel. The block therefore keeps them in a small queue of capture slots. A frame that starts while the previous trailer is still blocked by downstream backpressure gets a slot of its own. If more frame starts pile up than there are slots, a sticky flag reports it. Two configuration bits shape the time value. One picks a binary seconds word or a packed-BCD time word. The other picks the local time decoder or a time source forwarded from another board, and that choice covers both the seconds word and the second-boundary pulse. The block clock is the tick clock, nominally 40 MHz.

Top module: `frame_trailer_appender`

## Requirements
- R1: Each accepted input byte appears once on the output, unchanged and in input order, ahead of its frame's trailer. A frame of N bytes gives exactly N+32 output bytes.
- R2: Trailer bytes 0..3 hold the constant 0x45445401, least significant byte first, giving the byte sequence 01, 54, 44, 45.
- R3: out_last is high only on trailer byte 31. The input last flag never reaches the output.
- R4: Trailer bytes 4..7 (little-endian) hold the frame counter value at the frame's start edge. The counter then steps by one for every start edge.
- R5: While intf_reset is high the frame counter stays at zero. A frame started under intf_reset, and the first frame after it is released, both report 0.
- R6: Trailer bytes 8..11 (little-endian) hold the seconds word sampled at the start edge. It is the BCD word when cfg_raw=1 and the binary word when cfg_raw=0.
- R7: With cfg_slave=1 the forwarded seconds words and forwarded pulse are used, and the local pulse has no effect on the tick count. With cfg_slave=0 the local inputs are used.
- R8: Trailer bytes 12..15 (little-endian) hold the tick count at the start edge. The count is 0 on the first edge after a second pulse is sampled and rises by 1 per clock. If a pulse and a start edge are sampled on the same edge, the value from before the restart is latched.
- R9: Trailer bytes 16..19 (little-endian) hold the number of clock edges between the two most recent second pulses, as seen at the start edge. Bytes 20..31 are zero.
- R10: While out_valid=1 and out_ready=0, out_data and out_last hold. in_ready is low while a trailer is being produced.
- R11: A start edge that comes while an earlier trailer is still pending is stored in the next slot. That later frame's trailer carries its own captured values, and overflow stays low.
- R12: A start edge that comes while every slot (default 2) is pending sets overflow. overflow stays high until rst.
- R13: After rst, out_valid=0, overflow=0, and in_ready=1 when out_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_raw | input | 1 | 1: packed-BCD seconds word, 0: binary seconds |
| cfg_slave | input | 1 | 1: forwarded time source, 0: local time source |
| intf_reset | input | 1 | Holds the frame counter at zero while high |
| frame_valid | input | 1 | Frame strobe; its rising edge captures the time |
| loc_secs_bin | input | 32 | Local binary seconds |
| loc_secs_bcd | input | 32 | Local packed-BCD time word |
| loc_pps | input | 1 | Local second-boundary pulse |
| fwd_secs_bin | input | 32 | Forwarded binary seconds |
| fwd_secs_bcd | input | 32 | Forwarded packed-BCD time word |
| fwd_pps | input | 1 | Forwarded second-boundary pulse |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input pixel byte |
| in_last | input | 1 | Last byte of the frame |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final trailer byte |
| out_ready | input | 1 | Downstream accepts the output byte |
| overflow | output | 1 | Sticky: a frame start found no free slot |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a second pulse and a frame start. The bench raises the pulse and frame_valid on the same edge and expects the trailer to carry the tick count and previous-second length from before the restart. The second pair is a slot release and a new capture. The bench holds out_ready low so that a trailer stays pending, raises further frame starts, and then judges two things: the second frame's trailer must hold its own edge-derived values, and overflow must rise exactly when a start edge comes while every slot is taken. Every expected tick value is worked out from the bench's own edge numbers for the pulses and start edges.

// File: rtl/ftap_pkg.sv
`timescale 1ns/1ps
package ftap_pkg;
  localparam int unsigned TRL_BYTES = 32;
  localparam int unsigned TRL_IDX_W = $clog2(TRL_BYTES);
  localparam int unsigned FIELD_W   = 32;
  localparam logic [FIELD_W-1:0] TRL_MAGIC = 32'h4544_5401;

  typedef struct packed {
    logic [FIELD_W-1:0] secs;
    logic [FIELD_W-1:0] ticks;
    logic [FIELD_W-1:0] prev_ticks;
    logic [FIELD_W-1:0] frame;
  } cap_rec_t;

  typedef enum logic {ST_PIX = 1'b0, ST_TRL = 1'b1} emit_st_t;
endpackage

// File: rtl/ftap_tick_timer.sv
`timescale 1ns/1ps
module ftap_tick_timer #(
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pps,
  output logic [TICK_W-1:0] ticks,
  output logic [TICK_W-1:0] prev_ticks
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ticks      <= '0;
      prev_ticks <= '0;
    end else if (pps) begin
      ticks      <= '0;
      prev_ticks <= ticks + 1'b1;
    end else begin
      ticks      <= ticks + 1'b1;
    end
  end
endmodule

// File: rtl/ftap_capture_queue.sv
`timescale 1ns/1ps
module ftap_capture_queue
  import ftap_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  cap_rec_t rec_in,
  input  logic     pop,
  output cap_rec_t head,
  output logic     overflow
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  cap_rec_t             slots [DEPTH];
  logic [PTR_W-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]     fill;
  logic                 full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill == CNT_W'(DEPTH));
  assign do_pop  = pop && (fill != '0);
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= rec_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push && !do_pop)      fill <= fill + CNT_W'(1);
      else if (do_pop && !do_push) fill <= fill - CNT_W'(1);
      if (push && !do_push) overflow <= 1'b1;
    end
  end

  assign head = slots[rd_ptr];
endmodule

// File: rtl/ftap_trailer_sel.sv
`timescale 1ns/1ps
module ftap_trailer_sel
  import ftap_pkg::*;
(
  input  logic [TRL_IDX_W-1:0] idx,
  input  cap_rec_t             rec,
  output logic [7:0]           byte_out
);
  logic [FIELD_W-1:0] word;

  always_comb begin
    case (idx[TRL_IDX_W-1:2])
      3'd0:    word = TRL_MAGIC;
      3'd1:    word = rec.frame;
      3'd2:    word = rec.secs;
      3'd3:    word = rec.ticks;
      3'd4:    word = rec.prev_ticks;
      default: word = '0;
    endcase
    byte_out = word[8*idx[1:0] +: 8];
  end
endmodule

// File: rtl/frame_trailer_appender.sv
`timescale 1ns/1ps
module frame_trailer_appender
  import ftap_pkg::*;
#(
  parameter int unsigned CAP_DEPTH = 2,
  parameter int unsigned TICK_W    = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_raw,
  input  logic        cfg_slave,
  input  logic        intf_reset,
  input  logic        frame_valid,
  input  logic [31:0] loc_secs_bin,
  input  logic [31:0] loc_secs_bcd,
  input  logic        loc_pps,
  input  logic [31:0] fwd_secs_bin,
  input  logic [31:0] fwd_secs_bcd,
  input  logic        fwd_pps,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic        overflow
);
  localparam logic [TRL_IDX_W-1:0] IDX_LAST = TRL_IDX_W'(TRL_BYTES - 1);

  logic               pps_sel;
  logic [31:0]        secs_sel;
  logic [TICK_W-1:0]  tick_now, tick_prev;
  logic               fv_q, fv_rise;
  logic [FIELD_W-1:0] frame_cnt;
  cap_rec_t           cap_new, cap_head;
  emit_st_t           state;
  logic [TRL_IDX_W-1:0] idx;
  logic [7:0]         trl_byte;
  logic               load_ok, slot_pop;

  // time source selection
  assign pps_sel  = cfg_slave ? fwd_pps : loc_pps;
  assign secs_sel = cfg_slave ? (cfg_raw ? fwd_secs_bcd : fwd_secs_bin)
                              : (cfg_raw ? loc_secs_bcd : loc_secs_bin);

  ftap_tick_timer #(.TICK_W(TICK_W)) timer_i (
    .clk(clk), .rst(rst), .pps(pps_sel),
    .ticks(tick_now), .prev_ticks(tick_prev)
  );

  assign fv_rise = frame_valid && !fv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fv_q      <= 1'b0;
      frame_cnt <= '0;
    end else begin
      fv_q <= frame_valid;
      if (intf_reset)   frame_cnt <= '0;
      else if (fv_rise) frame_cnt <= frame_cnt + 1'b1;
    end
  end

  always_comb begin
    cap_new.secs       = secs_sel;
    cap_new.ticks      = FIELD_W'(tick_now);
    cap_new.prev_ticks = FIELD_W'(tick_prev);
    cap_new.frame      = frame_cnt;
  end

  assign slot_pop = out_valid && out_ready && out_last;

  ftap_capture_queue #(.DEPTH(CAP_DEPTH)) queue_i (
    .clk(clk), .rst(rst), .push(fv_rise), .rec_in(cap_new),
    .pop(slot_pop), .head(cap_head), .overflow(overflow)
  );

  ftap_trailer_sel sel_i (.idx(idx), .rec(cap_head), .byte_out(trl_byte));

  assign load_ok  = !out_valid || out_ready;
  assign in_ready = (state == ST_PIX) && load_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PIX;
      idx       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load_ok) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (state == ST_PIX) begin
        if (in_valid) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          if (in_last) begin
            state <= ST_TRL;
            idx   <= '0;
          end
        end
      end else begin
        out_valid <= 1'b1;
        out_data  <= trl_byte;
        out_last  <= (idx == IDX_LAST);
        idx       <= idx + 1'b1;
        if (idx == IDX_LAST) state <= ST_PIX;
      end
    end
  end
endmodule

// File: rtl/frame_trailer_appender_chk.sv
`timescale 1ns/1ps
module frame_trailer_appender_chk #(
  parameter int unsigned TICK_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              intf_reset,
  input logic              fv_rise,
  input logic [31:0]       frame_cnt,
  input logic              pps_sel,
  input logic [TICK_W-1:0] tick_now,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              overflow
);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R5
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    intf_reset |=> frame_cnt == 32'd0);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    fv_rise && !intf_reset |=> frame_cnt == $past(frame_cnt) + 32'd1);

  // R8
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    pps_sel |=> tick_now == '0);
endmodule

bind frame_trailer_appender frame_trailer_appender_chk #(.TICK_W(TICK_W)) chk_i (
  .clk(clk), .rst(rst), .intf_reset(intf_reset), .fv_rise(fv_rise),
  .frame_cnt(frame_cnt), .pps_sel(pps_sel), .tick_now(tick_now),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .overflow(overflow)
);

// File: tb/frame_trailer_appender_tb_top.sv
`timescale 1ns/1ps
module frame_trailer_appender_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_raw = 1'b0, cfg_slave = 1'b0, intf_reset = 1'b0;
  logic frame_valid = 1'b0;
  logic [31:0] loc_secs_bin = 32'h1234_5678, loc_secs_bcd = 32'h0012_3456;
  logic [31:0] fwd_secs_bin = 32'hCAFE_0001, fwd_secs_bcd = 32'h0023_5959;
  logic loc_pps = 1'b0, fwd_pps = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last, overflow;
  logic [7:0] out_data;
  logic out_ready = 1'b1;

  frame_trailer_appender dut_i (
    .clk(clk), .rst(rst), .cfg_raw(cfg_raw), .cfg_slave(cfg_slave),
    .intf_reset(intf_reset), .frame_valid(frame_valid),
    .loc_secs_bin(loc_secs_bin), .loc_secs_bcd(loc_secs_bcd), .loc_pps(loc_pps),
    .fwd_secs_bin(fwd_secs_bin), .fwd_secs_bcd(fwd_secs_bcd), .fwd_pps(fwd_pps),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .overflow(overflow)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  logic [7:0] obs_data [0:4095];
  bit         obs_last [0:4095];
  int obs_n = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int exp_frame = 0;

  // ready pattern first, then record the handshake the next edge will see
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[5];
      default: out_ready = 1'b0;
    endcase
    if (!rst && out_valid && out_ready && obs_n < 4096) begin
      obs_data[obs_n] = out_data;
      obs_last[obs_n] = out_last;
      obs_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 3) & 255);
  endfunction

  function automatic logic [31:0] word_at(input int o);
    return {obs_data[o+3], obs_data[o+2], obs_data[o+1], obs_data[o]};
  endfunction

  task automatic pps_pulse(input bit fwd, output int edge_no);
    @(negedge clk); #1;
    if (fwd) fwd_pps = 1'b1; else loc_pps = 1'b1;
    edge_no = cyc + 1;
    @(negedge clk); #1;
    fwd_pps = 1'b0; loc_pps = 1'b0;
  endtask

  task automatic prep_second(input bit fwd, input int gap, output int p2, output int prevv);
    int p1;
    pps_pulse(fwd, p1);
    repeat (gap) @(negedge clk);
    pps_pulse(fwd, p2);
    prevv = p2 - p1;
  endtask

  task automatic frame_rise(output int edge_no, output int fr);
    @(negedge clk); #1;
    frame_valid = 1'b1;
    edge_no = cyc + 1;
    fr = intf_reset ? 0 : exp_frame;
    exp_frame = intf_reset ? 0 : exp_frame + 1;
  endtask

  task automatic frame_fall();
    @(negedge clk); #1;
    frame_valid = 1'b0;
  endtask

  task automatic send_bytes(input int n, input int seed);
    int i = 0;
    while (i < n) begin
      @(negedge clk); #1;
      in_valid = 1'b1;
      in_data  = pix(seed, i);
      in_last  = (i == n - 1);
      if (in_ready) i++;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_out(input int target, input string req);
    int t = 0;
    while (obs_n < target && t < 3000) begin
      @(negedge clk); t++;
    end
    chk(obs_n >= target, req, "output byte count reached", obs_n, target);
  endtask

  task automatic check_frame(input int base, input int n, input int seed, input int fr,
                             input logic [31:0] secs, input int tick, input int prevv,
                             input string tag);
    int miss = 0, lastbad = 0, zbad = 0;
    int t0 = base + n;
    wait_out(t0 + 32, "R1");
    for (int k = 0; k < n; k++) if (obs_data[base+k] != pix(seed, k)) miss++;
    chk(miss == 0, "R1", {tag, " pixel bytes"}, miss, 0);
    for (int k = 0; k < n + 32; k++)
      if (obs_last[base+k] != (k == n + 31)) lastbad++;
    chk(lastbad == 0, "R3", {tag, " last flag placement"}, lastbad, 0);
    chk(word_at(t0) == 32'h4544_5401 && obs_data[t0] == 8'h01, "R2", {tag, " magic"},
        word_at(t0), 32'h4544_5401);
    chk(word_at(t0+4) == 32'(fr), "R4", {tag, " frame field"}, word_at(t0+4), fr);
    chk(word_at(t0+8) == secs, "R6", {tag, " seconds field"}, word_at(t0+8), secs);
    chk(word_at(t0+12) == 32'(tick), "R8", {tag, " tick field"}, word_at(t0+12), tick);
    chk(word_at(t0+16) == 32'(prevv), "R9", {tag, " previous second"}, word_at(t0+16), prevv);
    for (int k = 20; k < 32; k++) if (obs_data[t0+k] != 8'h00) zbad++;
    chk(zbad == 0, "R9", {tag, " zero padding"}, zbad, 0);
  endtask

  // one plain frame through the local source
  task automatic run_frame(input int n, input int seed, input int mode,
                           input logic [31:0] secs, input string tag);
    int p2, pv, f, fr, base;
    rdy_mode = mode;
    base = obs_n;
    prep_second(cfg_slave, 9 + seed % 5, p2, pv);
    repeat (3) @(negedge clk);
    frame_rise(f, fr);
    send_bytes(n, seed);
    frame_fall();
    check_frame(base, n, seed, fr, secs, f - p2 - 1, pv, tag);
    repeat (4) @(negedge clk);
    chk(obs_n == base + n + 32, "R1", {tag, " exact length"}, obs_n, base + n + 32);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R13", "out_valid after reset", out_valid, 0);
    chk(overflow == 1'b0, "R13", "overflow after reset", overflow, 0);
    chk(in_ready == 1'b1, "R13", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_basic();
    int p2, pv, f, fr, base;
    rdy_mode = 0;
    base = obs_n;
    prep_second(1'b0, 10, p2, pv);
    repeat (2) @(negedge clk);
    frame_rise(f, fr);
    send_bytes(5, 1);
    chk(in_ready == 1'b0, "R10", "in_ready low in trailer", in_ready, 0);
    frame_fall();
    check_frame(base, 5, 1, fr, loc_secs_bin, f - p2 - 1, pv, "basic");
  endtask

  task automatic t_slave();
    int p2, pv, pl, f, fr, base;
    cfg_slave = 1'b1;
    rdy_mode = 0;
    base = obs_n;
    prep_second(1'b1, 12, p2, pv);
    repeat (2) @(negedge clk);
    pps_pulse(1'b0, pl);   // local pulse must not touch ticks (R7)
    repeat (2) @(negedge clk);
    frame_rise(f, fr);
    send_bytes(6, 4);
    frame_fall();
    check_frame(base, 6, 4, fr, fwd_secs_bin, f - p2 - 1, pv, "R7 slave");
    cfg_slave = 1'b0;
  endtask

  task automatic t_intf_reset();
    int p2, pv, f, fr, base;
    rdy_mode = 0;
    @(negedge clk); #1; intf_reset = 1'b1; exp_frame = 0;
    base = obs_n;
    prep_second(1'b0, 8, p2, pv);
    frame_rise(f, fr);
    send_bytes(4, 6);
    frame_fall();
    check_frame(base, 4, 6, fr, loc_secs_bin, f - p2 - 1, pv, "R5 held");
    @(negedge clk); #1; intf_reset = 1'b0;
    run_frame(3, 7, 0, loc_secs_bin, "R5 released");
  endtask

  task automatic t_queue();
    int p2, pv, fa, fra, fb, frb, base_a, base_b;
    rdy_mode = 0;
    base_a = obs_n;
    prep_second(1'b0, 11, p2, pv);
    frame_rise(fa, fra);
    send_bytes(8, 9);
    rdy_mode = 2;
    frame_fall();
    repeat (3) @(negedge clk);
    frame_rise(fb, frb);
    frame_fall();
    repeat (5) @(negedge clk);
    chk(overflow == 1'b0, "R11", "no overflow with second pending", overflow, 0);
    rdy_mode = 1;
    base_b = base_a + 8 + 32;
    send_bytes(7, 10);
    check_frame(base_a, 8, 9, fra, loc_secs_bin, fa - p2 - 1, pv, "R11 first");
    check_frame(base_b, 7, 10, frb, loc_secs_bin, fb - p2 - 1, pv, "R11 second");
    rdy_mode = 0;
  endtask

  task automatic t_coincide();
    int p2, pv, e, base;
    rdy_mode = 0;
    base = obs_n;
    prep_second(1'b0, 10, p2, pv);
    repeat (6) @(negedge clk);
    @(negedge clk); #1;
    loc_pps = 1'b1; frame_valid = 1'b1;
    e = cyc + 1;
    @(negedge clk); #1;
    loc_pps = 1'b0;
    send_bytes(4, 12);
    frame_fall();
    check_frame(base, 4, 12, exp_frame, loc_secs_bin, e - p2 - 1, pv, "R8 coincident");
    exp_frame++;
  endtask

  task automatic t_overflow();
    int f, fr;
    rdy_mode = 0;
    frame_rise(f, fr);
    send_bytes(3, 14);
    rdy_mode = 2;
    frame_fall();
    frame_rise(f, fr);
    frame_fall();
    repeat (2) @(negedge clk);
    chk(overflow == 1'b0, "R12", "two pending, no overflow", overflow, 0);
    frame_rise(f, fr);
    frame_fall();
    repeat (2) @(negedge clk);
    chk(overflow == 1'b1, "R12", "third pending sets overflow", overflow, 1);
    rdy_mode = 0;
    repeat (100) @(negedge clk);
    chk(overflow == 1'b1, "R12", "overflow sticky", overflow, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    run_frame(20, 2, 1, loc_secs_bin, "R10 backpressure");
    cfg_raw = 1'b1;
    run_frame(6, 3, 0, loc_secs_bcd, "R6 raw");
    cfg_raw = 1'b0;
    t_slave();
    t_intf_reset();
    t_queue();
    t_coincide();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule